// File: doc/BRIEF.md
# Timer Channel Clock Front End

This block is the counting front end of one timer channel. It picks one of eight candidate clock sources: five prescaled internal ticks and three external inputs. It can invert the chosen source, and it can AND the result with one of the external inputs to gate it. Each active edge of the resulting signal advances a 16-bit up-counter. All of this runs in the system clock domain. The source level is sampled on every system clock, and each detected rising edge of the processed level is one count.

A small control state machine decides when edges count. It has three states:
- `ST_OFF`: the channel is disabled and the count holds.
- `ST_RUN`: the channel counts edges.
- `ST_HOLD`: the counter froze itself when it reached the compare value.

It has four transitions:
- *arm*: `ST_OFF` to `ST_RUN` on a start pulse.
- *park*: any state to `ST_OFF` on a stop pulse.
- *freeze*: `ST_RUN` to `ST_HOLD` when the count reaches the compare value while stop-on-compare is enabled.
- *retrigger*: `ST_HOLD` to `ST_RUN` on a software trigger.

A software trigger also clears the count in every state. A one-cycle pulse marks the moment the count becomes equal to the compare value.

Software writes three registers, selected by address:
- Address 0 is the mode register: source code in bits [2:0], invert in bit 3, gate code in bits [5:4], stop-on-compare in bit 6.
- Address 1 is the 16-bit compare value.
- Address 2 holds the lock bit in bit 0. While the lock bit is set, mode writes are ignored.

Top module: `tmr_chan_front`

## Requirements
- R1: Mode source code s in 0..4 selects `tick_int[s]`; codes 5, 6 and 7 select `ext_in[0]`, `ext_in[1]` and `ext_in[2]`.
- R2: With mode bit 3 (invert) set, the counter advances on falling edges of the selected source instead of rising edges.
- R3: Mode gate code g (bits [5:4]) equal to 0 leaves the source ungated. A value g of 1 to 3 ANDs the (possibly inverted) source with `ext_in[g-1]`.
- R4: The processed level is sampled on every system clock. In `ST_RUN`, each cycle where it is 1 and was 0 on the previous clock adds exactly one to `count` at that clock edge. The count wraps from 0xFFFF to 0.
- R5: A `start` pulse moves `ST_OFF` to `ST_RUN`. A `stop` pulse moves any state to `ST_OFF` and wins over `start`. Outside `ST_RUN`, `count` never increments. `running` is 1 only in `ST_RUN`.
- R6: With mode bit 6 set, the increment that makes `count` equal to the compare value enters `ST_HOLD`. The count then stays at that value and `frozen` reads 1.
- R7: With mode bit 6 clear, reaching the compare value does not stop counting: the count passes it and later wraps through 0.
- R8: `match` is 1 for exactly the one system clock following the increment that made `count` equal to the compare value.
- R9: A `sw_trig` pulse sets `count` to 0 in every state and takes `ST_HOLD` (or `ST_RUN`) to `ST_RUN`. An increment in the same cycle is dropped.
- R10: While lock bit 0 at address 2 is 1, writes to the mode register (address 0) are ignored. Compare writes (address 1) still take effect.
- R11: After reset: `count` = 0, `match` = 0, `running` = 0, `frozen` = 0, and mode, compare value and lock are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_int | input | 5 | Internal prescaled tick levels, source codes 0..4 |
| ext_in | input | 3 | External clock/gate levels, source codes 5..7 and gate codes 1..3 |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0 mode, 1 compare, 2 lock) |
| cfg_wdata | input | 16 | Register write data |
| start | input | 1 | Enable pulse (arm) |
| stop | input | 1 | Disable pulse (park) |
| sw_trig | input | 1 | Software trigger: clear count and retrigger |
| count | output | 16 | Current counter value |
| match | output | 1 | One-cycle pulse after the count becomes equal to the compare value |
| running | output | 1 | State is `ST_RUN` |
| frozen | output | 1 | State is `ST_HOLD` |

## Verification
Several properties are checked by assertions on every cycle:
- The edge detector never reports two rises in a row.
- The count holds whenever the state is not `ST_RUN`, and moves by at most one while it is.
- Entry into `ST_HOLD` happens with the count equal to the compare value.
- `match` is never high for two cycles.
- A trigger always leaves the count at zero.
- A locked mode write leaves the mode unchanged.

Only the bench scenarios can show the rest:
- Each of the eight source codes, the inversion and the three gate inputs pick the intended signal.
- The count really wraps through 0 after 65536 edges.
- The halt and retrigger sequence happens in the right order under the stated priorities.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
    localparam int NUM_INT = 5;
    localparam int NUM_EXT = 3;
    localparam int SRC_W   = $clog2(NUM_INT + NUM_EXT);
    localparam int GATE_W  = $clog2(NUM_EXT + 1);

    typedef struct packed {
        logic              halt;
        logic [GATE_W-1:0] gate;
        logic              inv;
        logic [SRC_W-1:0]  src;
    } mode_t;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } run_st_t;

    localparam logic [1:0] ADR_MODE = 2'd0;
    localparam logic [1:0] ADR_RC   = 2'd1;
    localparam logic [1:0] ADR_LOCK = 2'd2;
endpackage

// File: rtl/tcf_src_sel.sv
module tcf_src_sel
    import tcf_pkg::*;
(
    input  logic [NUM_INT-1:0] int_clk,
    input  logic [NUM_EXT-1:0] ext_clk,
    input  mode_t              mode,
    output logic               level
);
    localparam int NSRC = NUM_INT + NUM_EXT;

    logic [NSRC-1:0] pool;
    logic            picked;
    logic            gate_ok;

    assign pool = {ext_clk, int_clk};

    // R1: source code picks one entry of the pool
    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (mode.src == SRC_W'(i)) picked = pool[i];
        end
    end

    // R3: gate code 0 passes, 1..NUM_EXT select an external input
    always_comb begin
        gate_ok = 1'b1;
        for (int k = 0; k < NUM_EXT; k++) begin
            if (mode.gate == GATE_W'(k + 1)) gate_ok = ext_clk[k];
        end
    end

    // R2: inversion before gating
    assign level = (picked ^ mode.inv) & gate_ok;
endmodule

// File: rtl/tcf_edge.sv
module tcf_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;

    // R4: a rise needs a low sample before it, so never two in a row
    assert_single_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/tcf_regs.sv
module tcf_regs
    import tcf_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    addr,
    input  logic [CW-1:0] wdata,
    output mode_t         mode,
    output logic [CW-1:0] rc,
    output logic          locked
);
    localparam int MW = $bits(mode_t);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode   <= '0;
            rc     <= '0;
            locked <= 1'b0;
        end else if (we) begin
            unique case (addr)
                ADR_MODE: if (!locked) mode <= mode_t'(wdata[MW-1:0]);
                ADR_RC:   rc     <= wdata;
                ADR_LOCK: locked <= wdata[0];
                default:  ;
            endcase
        end
    end

    assert_locked_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADR_MODE && locked) |=> mode == $past(mode));

    assert_rc_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADR_RC) |=> rc == $past(wdata));
endmodule

// File: rtl/tcf_fsm.sv
module tcf_fsm
    import tcf_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stop,
    input  logic          sw_trig,
    input  logic          rise,
    input  logic          halt_en,
    input  logic [CW-1:0] rc,
    output logic [CW-1:0] count,
    output logic          match,
    output logic          running,
    output logic          frozen
);
    run_st_t       st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_inc;
    logic          match_q;
    logic          step;
    logic          hit;

    assign cnt_inc = cnt_q + 1'b1;
    assign step    = (st_q == ST_RUN) && rise && !stop && !sw_trig;
    assign hit     = step && (cnt_inc == rc);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // next state: stop > sw_trig > start > compare freeze
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:  if (!stop && start) st_d = ST_RUN;
            ST_RUN: begin
                if (stop)                 st_d = ST_OFF;
                else if (sw_trig)         st_d = ST_RUN;
                else if (hit && halt_en)  st_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (stop)         st_d = ST_OFF;
                else if (sw_trig) st_d = ST_RUN;
            end
            default: st_d = ST_OFF;
        endcase
    end

    // outputs: counter and compare pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            match_q <= 1'b0;
        end else begin
            match_q <= hit;
            if (sw_trig)   cnt_q <= '0;
            else if (step) cnt_q <= cnt_inc;
        end
    end

    assign count   = cnt_q;
    assign match   = match_q;
    assign running = (st_q == ST_RUN);
    assign frozen  = (st_q == ST_HOLD);

    assert_off_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_RUN && !sw_trig) |=> cnt_q == $past(cnt_q));

    assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && !sw_trig) |=>
            (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

    assert_freeze_at_rc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && $past(st_q) == ST_RUN) |-> cnt_q == $past(rc));

    assert_match_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        match_q |=> !match_q);

    assert_retrig_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_trig |=> cnt_q == '0);
endmodule

// File: rtl/tmr_chan_front.sv
module tmr_chan_front
    import tcf_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_INT-1:0] tick_int,
    input  logic [NUM_EXT-1:0] ext_in,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_addr,
    input  logic [CW-1:0]      cfg_wdata,
    input  logic               start,
    input  logic               stop,
    input  logic               sw_trig,
    output logic [CW-1:0]      count,
    output logic               match,
    output logic               running,
    output logic               frozen
);
    mode_t         mode;
    logic [CW-1:0] rc;
    logic          locked;
    logic          level;
    logic          rise;

    tcf_regs #(.CW(CW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .mode   (mode),
        .rc     (rc),
        .locked (locked)
    );

    tcf_src_sel u_sel (
        .int_clk (tick_int),
        .ext_clk (ext_in),
        .mode    (mode),
        .level   (level)
    );

    tcf_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (level),
        .rise  (rise)
    );

    tcf_fsm #(.CW(CW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .stop    (stop),
        .sw_trig (sw_trig),
        .rise    (rise),
        .halt_en (mode.halt),
        .rc      (rc),
        .count   (count),
        .match   (match),
        .running (running),
        .frozen  (frozen)
    );
endmodule

// File: tb/sim_tmr_chan_front.sv
`timescale 1ns/1ps
module sim_tmr_chan_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  tick_int = '0;
    logic [2:0]  ext_in = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        start = 1'b0, stop = 1'b0, sw_trig = 1'b0;
    logic [15:0] count;
    logic        match, running, frozen;

    always #2 clk = ~clk;   // 250 MHz

    tmr_chan_front u0 (
        .clk(clk), .rst_n(rst_n), .tick_int(tick_int), .ext_in(ext_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .start(start), .stop(stop), .sw_trig(sw_trig),
        .count(count), .match(match), .running(running), .frozen(frozen)
    );

    int    total = 0;
    int    bad = 0;
    string cur_req = "R11";
    int    cyc = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // free-running source patterns, driven on the falling edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        tick_int <= 5'(cyc);
        ext_in[0] <= cyc[1];
        ext_in[1] <= cyc[2] ^ cyc[4];
        ext_in[2] <= cyc[3];
    end

    // behavioural reference model, updated on the rising edge
    bit [15:0] m_cnt, m_rc;
    int        m_st;               // 0 off, 1 run, 2 hold
    bit        m_match, m_prev, m_lock;
    bit [6:0]  m_mode;
    bit [7:0]  m_pool;
    bit        m_lvl, m_ev, m_step, m_hit;
    int        m_ns;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_rc = 0; m_st = 0; m_match = 0; m_prev = 0;
            m_lock = 0; m_mode = 0;
        end else begin
            m_pool = {ext_in, tick_int};
            m_lvl  = m_pool[m_mode[2:0]] ^ m_mode[3];
            if (m_mode[5:4] != 0) m_lvl = m_lvl & ext_in[m_mode[5:4] - 1];
            m_ev   = m_lvl && !m_prev;
            m_step = (m_st == 1) && m_ev && !stop && !sw_trig;
            m_hit  = m_step && (16'(m_cnt + 1) == m_rc);
            m_ns   = m_st;
            if (stop)                         m_ns = 0;
            else if (m_st == 0 && start)      m_ns = 1;
            else if (m_st != 0 && sw_trig)    m_ns = 1;
            else if (m_hit && m_mode[6])      m_ns = 2;
            if (sw_trig)     m_cnt = 0;
            else if (m_step) m_cnt = 16'(m_cnt + 1);
            m_match = m_hit;
            m_prev  = m_lvl;
            m_st    = m_ns;
            if (cfg_we) begin
                if (cfg_addr == 0 && !m_lock) m_mode = cfg_wdata[6:0];
                if (cfg_addr == 1)            m_rc = cfg_wdata;
                if (cfg_addr == 2)            m_lock = cfg_wdata[0];
            end
        end
    end

    // per-cycle comparison and wrap/match monitors
    bit [15:0] last_cnt = 0;
    bit        seen_wrap = 0;
    int        match_seen = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            chk({count, match, running, frozen} ==
                {m_cnt, m_match, m_st == 1, m_st == 2}, cur_req,
                {count, match, running, frozen},
                {m_cnt, m_match, m_st == 1, m_st == 2});
            if (last_cnt == 16'hFFFF && count == 16'h0000) seen_wrap = 1;
            if (match) match_seen++;
            last_cnt = count;
        end
    end

    task automatic cfg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    endtask
    task automatic pulse_stop();
        @(negedge clk); stop = 1'b1; @(negedge clk); stop = 1'b0;
    endtask
    task automatic pulse_trig();
        @(negedge clk); sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0;
    endtask

    function automatic logic [15:0] mk_mode(int src, bit inv, int gate, bit halt);
        return 16'({halt, 2'(gate), inv, 3'(src)});
    endfunction

    initial begin
        bit [15:0] held;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(count == 0 && !match && !running && !frozen, "R11", {count, match, running, frozen}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(count == 0 && !running, "R11", count, 0);

        cur_req = "R5";
        pulse_start();
        chk(running == 1, "R5", running, 1);

        // R1: every source code
        cur_req = "R1";
        for (int s = 0; s < 8; s++) begin
            pulse_trig();
            cfg(0, mk_mode(s, 0, 0, 0));
            repeat (64) @(negedge clk);
            chk(count > 0, "R1", count, 1);
        end

        // R2: inverted source
        cur_req = "R2";
        pulse_trig();
        cfg(0, mk_mode(1, 1, 0, 0));
        repeat (64) @(negedge clk);
        chk(count > 0, "R2", count, 1);

        // R3: each gate input on the fast source
        cur_req = "R3";
        for (int g = 1; g < 4; g++) begin
            pulse_trig();
            cfg(0, mk_mode(0, 0, g, 0));
            repeat (64) @(negedge clk);
            chk(count > 0 && count < 32, "R3", count, 16);
        end

        // R5: stop holds the count, stop wins over start
        cur_req = "R5";
        cfg(0, mk_mode(0, 0, 0, 0));
        pulse_stop();
        held = count;
        repeat (30) @(negedge clk);
        chk(count == held && !running, "R5", count, held);
        @(negedge clk); start = 1'b1; stop = 1'b1;
        @(negedge clk); start = 1'b0; stop = 1'b0;
        chk(!running, "R5", running, 0);
        pulse_start();

        // R6: freeze at compare value
        cur_req = "R6";
        cfg(1, 16'd5);
        cfg(0, mk_mode(0, 0, 0, 1));
        pulse_trig();
        for (int i = 0; i < 100 && !frozen; i++) @(negedge clk);
        chk(frozen && count == 5, "R6", count, 5);
        repeat (20) @(negedge clk);
        chk(frozen && count == 5, "R6", count, 5);

        // R9: trigger clears and retriggers
        cur_req = "R9";
        pulse_trig();
        chk(count == 0 && running, "R9", count, 0);

        // R10: locked mode write ignored, compare write still applies
        cur_req = "R10";
        cfg(0, mk_mode(0, 0, 0, 0));
        cfg(2, 16'd1);
        cfg(0, mk_mode(7, 0, 0, 0));
        pulse_trig();
        repeat (20) @(negedge clk);
        chk(count >= 9, "R10", count, 10);
        cfg(1, 16'd2);
        cfg(2, 16'd0);

        // R7 / R8: pass the compare value and wrap
        cur_req = "R7";
        pulse_trig();
        match_seen = 0;
        repeat (40) @(negedge clk);
        chk(count > 2 && running, "R7", count, 3);
        seen_wrap = 0;
        for (int i = 0; i < 140000 && !seen_wrap; i++) @(negedge clk);
        chk(seen_wrap, "R7", seen_wrap, 1);
        repeat (20) @(negedge clk);
        cur_req = "R8";
        chk(match_seen == 2, "R8", match_seen, 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog %s actual=timeout expected=done", cur_req);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule